// File: doc/BRIEF.md
# Trapezoid Span Walker

This block steps down a trapezoid one scanline at a time. A host fills a small bank of control registers with the start X of the dominant edge, the start X of the subordinate edge, the start Y, a line count, and a per-line step for each of the two X edges and for Y. A command is then written on a separate command port. A begin command copies the three start values into the walker's working position and then emits spans. A continue command keeps whatever position the previous primitive left behind and emits further spans from there. A sync command, or the reserved code, starts no drawing.

Each span leaves on a valid/ready stream as one Y value and the two edge X values. While a primitive is being walked, the command port holds its ready low, so the next command waits until the last span has been taken. All coordinate arithmetic wraps modulo the field width. The steps are two's-complement values, so an edge can move left or right.

Top module: `span_walker`

## Requirements
- R1: After reset, `cmd_ready` is 1, `span_valid` is 0, and all control and working registers are zero.
- R2: A begin command (`cmd_op` = 2'b01) loads the working position from the start registers. The first span it produces carries exactly the start dominant X, start subordinate X and start Y.
- R3: Each span taken (`span_valid` and `span_ready` both high at a clock edge) adds the dominant step, subordinate step and Y step to the working position, modulo 2^width. The next span carries the result.
- R4: A draw command with a nonzero line count N produces exactly N spans. After the last span is taken, the block is idle with `cmd_ready` high and `span_valid` low.
- R5: A continue command (`cmd_op` = 2'b10) does not reload anything. Its first span carries the position that follows the last span of the previous primitive. Its own line count is taken from the count register.
- R6: A sync command (`cmd_op` = 2'b00) or the reserved code 2'b11 emits no span, leaves the working position unchanged, and keeps `cmd_ready` high on the following cycle.
- R7: A draw command with a line count of zero emits no span and is ready again on the next cycle. A begin still loads the start values; a continue leaves the position untouched.
- R8: While any span of a primitive is pending, `cmd_ready` is 0, so further commands are held off.
- R9: While `span_valid` is high and `span_ready` is low, `span_valid` stays high and all three span fields keep their values.
- R10: Control writes pick a register with `cfg_sel`: 0 dominant start X, 1 subordinate start X, 2 start Y, 3 line count, 4 dominant X step, 5 subordinate X step, 6 Y step. Each register takes the low bits of `cfg_wdata`. Select 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 3 | Control register select |
| cfg_wdata | input | DW | Control register write data |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code: 00 sync, 01 begin, 10 continue, 11 reserved |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| span_valid | output | 1 | Span available |
| span_ready | input | 1 | Consumer takes the span |
| span_xdom | output | XW | Dominant edge X of the span |
| span_xsub | output | XW | Subordinate edge X of the span |
| span_y | output | YW | Scanline Y of the span |

## Verification
The hardest state to observe from the ports is the working position left after a primitive ends. It only becomes visible in the first span of a later continue command. The stimulus therefore chains begin and continue commands over a sweep of line counts that includes zero. It places sync and reserved commands between them, and checks the first span of each continue against the model's position. Start values near the top of the range, combined with negative steps, force the wrap. A pseudo-random `span_ready` pattern creates stalls in the middle of a walk.

// File: rtl/span_walker_pkg.sv
// Package: shared command codes and control register selects for the span walker.
// Assumes: 2-bit command code and 3-bit register select at the block edge.
package span_walker_pkg;

    typedef enum logic [1:0] {
        OP_SYNC  = 2'b00,
        OP_BEGIN = 2'b01,
        OP_CONT  = 2'b10,
        OP_RSVD  = 2'b11
    } walk_op_e;

    localparam logic [2:0] SEL_XDOM_ST = 3'd0;
    localparam logic [2:0] SEL_XSUB_ST = 3'd1;
    localparam logic [2:0] SEL_Y_ST    = 3'd2;
    localparam logic [2:0] SEL_COUNT   = 3'd3;
    localparam logic [2:0] SEL_XDOM_IN = 3'd4;
    localparam logic [2:0] SEL_XSUB_IN = 3'd5;
    localparam logic [2:0] SEL_Y_IN    = 3'd6;

    // True when a command code asks for spans to be drawn.
    function automatic logic op_draws(input logic [1:0] op);
        return (op == OP_BEGIN) || (op == OP_CONT);
    endfunction

endpackage

// File: rtl/span_ctl_regs.sv
// Module: host control register bank. Holds start values, line count and
// per-line steps. Assumes only the host writes; the walker only reads.
// Unused selects are ignored. All fields reset to zero.
module span_ctl_regs
    import span_walker_pkg::*;
#(
    parameter int DW = 16,
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [XW-1:0] st_xdom,
    output logic [XW-1:0] st_xsub,
    output logic [YW-1:0] st_y,
    output logic [CW-1:0] st_cnt,
    output logic [XW-1:0] inc_xdom,
    output logic [XW-1:0] inc_xsub,
    output logic [YW-1:0] inc_y
);

    // Register bank update: one field per write, selected by cfg_sel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_xdom  <= '0;
            st_xsub  <= '0;
            st_y     <= '0;
            st_cnt   <= '0;
            inc_xdom <= '0;
            inc_xsub <= '0;
            inc_y    <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_XDOM_ST: st_xdom  <= cfg_wdata[XW-1:0];
                SEL_XSUB_ST: st_xsub  <= cfg_wdata[XW-1:0];
                SEL_Y_ST:    st_y     <= cfg_wdata[YW-1:0];
                SEL_COUNT:   st_cnt   <= cfg_wdata[CW-1:0];
                SEL_XDOM_IN: inc_xdom <= cfg_wdata[XW-1:0];
                SEL_XSUB_IN: inc_xsub <= cfg_wdata[XW-1:0];
                SEL_Y_IN:    inc_y    <= cfg_wdata[YW-1:0];
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/span_axis_reg.sv
// Module: one working coordinate. Loads its start value or advances by its
// step, wrapping modulo 2^W. Assumes load and advance are never high together.
module span_axis_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] start,
    input  logic [W-1:0] step,
    output logic [W-1:0] pos
);

    // Working position: reload on begin, step on each span taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (load)
            pos <= start;
        else if (adv)
            pos <= pos + step;
    end

endmodule

// File: rtl/span_seq.sv
// Module: command acceptance and span counting. Accepts a command only when
// idle. Begin asserts load; begin or continue with a nonzero count enters the
// walking state for that many spans. Assumes the count is stable at accept.
module span_seq
    import span_walker_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [CW-1:0] cnt_in,
    input  logic          span_ready,
    output logic          cmd_ready,
    output logic          span_valid,
    output logic          load,
    output logic          adv
);

    logic          busy;
    logic [CW-1:0] remain;
    logic          accept;

    // Handshake decode for the command port and the span stream.
    always_comb begin
        cmd_ready  = !busy;
        span_valid = busy;
        accept     = cmd_valid && !busy;
        load       = accept && (cmd_op == OP_BEGIN);
        adv        = busy && span_ready;
    end

    // Walk state: remaining spans, leaving the walking state after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (accept) begin
            if (op_draws(cmd_op) && (cnt_in != '0)) begin
                busy   <= 1'b1;
                remain <= cnt_in;
            end
        end else if (adv) begin
            remain <= remain - 1'b1;
            if (remain == CW'(1))
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/span_walker.sv
// Module: top of the span walker. Joins the control register bank, the command
// sequencer and three working coordinates. Spans leave on a valid/ready
// stream. Assumes XW, YW and CW are no wider than DW.
module span_walker #(
    parameter int DW = 16,
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    output logic          cmd_ready,
    output logic          span_valid,
    input  logic          span_ready,
    output logic [XW-1:0] span_xdom,
    output logic [XW-1:0] span_xsub,
    output logic [YW-1:0] span_y
);

    logic [XW-1:0] st_xdom, st_xsub, inc_xdom, inc_xsub;
    logic [YW-1:0] st_y, inc_y;
    logic [CW-1:0] st_cnt;
    logic          load, adv;

    span_ctl_regs #(.DW(DW), .XW(XW), .YW(YW), .CW(CW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .st_xdom(st_xdom), .st_xsub(st_xsub), .st_y(st_y), .st_cnt(st_cnt),
        .inc_xdom(inc_xdom), .inc_xsub(inc_xsub), .inc_y(inc_y)
    );

    span_seq #(.CW(CW)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cnt_in(st_cnt),
        .span_ready(span_ready),
        .cmd_ready(cmd_ready), .span_valid(span_valid),
        .load(load), .adv(adv)
    );

    span_axis_reg #(.W(XW)) xdom_i (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .start(st_xdom), .step(inc_xdom), .pos(span_xdom)
    );

    span_axis_reg #(.W(XW)) xsub_i (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .start(st_xsub), .step(inc_xsub), .pos(span_xsub)
    );

    span_axis_reg #(.W(YW)) y_i (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .start(st_y), .step(inc_y), .pos(span_y)
    );

endmodule

// File: rtl/span_walker_chk.sv
// Checker: temporal properties of the span walker, bound to the top module.
// Assumes a synchronous active-low reset.
module span_walker_chk
    import span_walker_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          cmd_ready,
    input logic          span_valid,
    input logic          span_ready,
    input logic [XW-1:0] span_xdom,
    input logic [XW-1:0] span_xsub,
    input logic [YW-1:0] span_y,
    input logic [XW-1:0] st_xdom,
    input logic [XW-1:0] st_xsub,
    input logic [YW-1:0] st_y,
    input logic [CW-1:0] st_cnt,
    input logic [XW-1:0] inc_xdom,
    input logic [XW-1:0] inc_xsub,
    input logic [YW-1:0] inc_y
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !span_valid));

    assert_begin_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_BEGIN && st_cnt != '0) |=>
        (span_valid && span_xdom == $past(st_xdom) &&
         span_xsub == $past(st_xsub) && span_y == $past(st_y)));

    assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (span_valid && span_ready) |=>
        (span_xdom == XW'($past(span_xdom) + $past(inc_xdom)) &&
         span_xsub == XW'($past(span_xsub) + $past(inc_xsub)) &&
         span_y    == YW'($past(span_y) + $past(inc_y))));

    assert_nodraw_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == OP_SYNC || cmd_op == OP_RSVD)) |=>
        (cmd_ready && !span_valid));

    assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op_draws(cmd_op) && st_cnt == '0) |=>
        (cmd_ready && !span_valid));

    assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |-> !cmd_ready);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (span_valid && !span_ready) |=>
        (span_valid && $stable(span_xdom) && $stable(span_xsub) && $stable(span_y)));

endmodule

bind span_walker span_walker_chk #(.XW(XW), .YW(YW), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .span_valid(span_valid), .span_ready(span_ready),
    .span_xdom(span_xdom), .span_xsub(span_xsub), .span_y(span_y),
    .st_xdom(st_xdom), .st_xsub(st_xsub), .st_y(st_y), .st_cnt(st_cnt),
    .inc_xdom(inc_xdom), .inc_xsub(inc_xsub), .inc_y(inc_y)
);

// File: tb/span_walker_tb.sv
// Bench: sweeps line counts and step sets through begin, continue, sync and
// zero-count commands under full-rate and stalling consumers; the expected
// spans come from a coordinate model kept in the bench.
module span_walker_tb_top;

    localparam int DW = 16;
    localparam int XW = 10;
    localparam int YW = 9;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic          cmd_ready;
    logic          span_valid;
    logic          span_ready = 1'b0;
    logic [XW-1:0] span_xdom, span_xsub;
    logic [YW-1:0] span_y;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit stall_mode = 1'b0;

    // Model of the coordinates and the step registers.
    logic [XW-1:0] m_xd, m_xs, s_xd, s_xs, p_xd, p_xs;
    logic [YW-1:0] m_y, s_y, p_y;

    always #4 clk = ~clk;

    span_walker #(.DW(DW), .XW(XW), .YW(YW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
        .span_valid(span_valid), .span_ready(span_ready),
        .span_xdom(span_xdom), .span_xsub(span_xsub), .span_y(span_y)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = DW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_trap(input int xd, input int xs, input int y,
                             input int dxd, input int dxs, input int dy);
        wr(3'd0, xd);  wr(3'd1, xs);  wr(3'd2, y);
        wr(3'd4, dxd); wr(3'd5, dxs); wr(3'd6, dy);
        s_xd = XW'(xd);  s_xs = XW'(xs);  s_y = YW'(y);
        p_xd = XW'(dxd); p_xs = XW'(dxs); p_y = YW'(dy);
    endtask

    // Presents a command; returns at the negedge after it was taken.
    task automatic issue(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Takes n spans and compares each with the model.
    task automatic collect(input int n, input string first_tag);
        int k = 0;
        bit stalled = 1'b0;
        logic [XW-1:0] h_xd, h_xs;
        logic [YW-1:0] h_y;
        while (k < n) begin
            @(negedge clk);
            span_ready = stall_mode ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (stalled) begin
                chk("R9", "held valid", int'(span_valid), 1);
                chk("R9", "held xdom", int'(span_xdom), int'(h_xd));
                chk("R9", "held xsub", int'(span_xsub), int'(h_xs));
                chk("R9", "held y", int'(span_y), int'(h_y));
            end
            if (span_valid) chk("R8", "cmd_ready while walking", int'(cmd_ready), 0);
            stalled = span_valid && !span_ready;
            h_xd = span_xdom; h_xs = span_xsub; h_y = span_y;
            if (span_valid && span_ready) begin
                chk(k == 0 ? first_tag : "R3", "span xdom", int'(span_xdom), int'(m_xd));
                chk(k == 0 ? first_tag : "R3", "span xsub", int'(span_xsub), int'(m_xs));
                chk(k == 0 ? first_tag : "R3", "span y", int'(span_y), int'(m_y));
                m_xd = m_xd + p_xd;
                m_xs = m_xs + p_xs;
                m_y  = m_y + p_y;
                k++;
            end
        end
        @(negedge clk);
        span_ready = 1'b0;
        #1;
        chk("R4", "valid after last span", int'(span_valid), 0);
        chk("R4", "ready after last span", int'(cmd_ready), 1);
    endtask

    // Runs one command with line count cnt and checks its outcome.
    task automatic run(input logic [1:0] op, input int cnt, input string first_tag);
        wr(3'd3, cnt);
        issue(op);
        if (op == 2'b01) begin
            m_xd = s_xd; m_xs = s_xs; m_y = s_y;
        end
        if ((op == 2'b01 || op == 2'b10) && cnt != 0) begin
            collect(cnt, first_tag);
        end else begin
            #1;
            chk(cnt == 0 && op[0] != op[1] ? "R7" : "R6", "no span", int'(span_valid), 0);
            chk(cnt == 0 && op[0] != op[1] ? "R7" : "R6", "ready", int'(cmd_ready), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset cmd_ready", int'(cmd_ready), 1);
        chk("R1", "reset span_valid", int'(span_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "idle after reset", int'(span_valid), 0);

        // R1: registers reset to zero; a begin of one line shows zero starts.
        wr(3'd3, 1);
        issue(2'b01);
        m_xd = '0; m_xs = '0; m_y = '0; p_xd = '0; p_xs = '0; p_y = '0;
        collect(1, "R1");

        // Sweep step sets, counts and consumer behaviour.
        for (int set = 0; set < 4; set++) begin
            for (int c = 0; c < 6; c++) begin
                stall_mode = (set % 2) == 1;
                case (set)
                    0: load_trap(10, 40, 5, 1, 3, 1);
                    1: load_trap(1020, 3, 508, 7, -5, 2);
                    2: load_trap(5, 1000, 0, -3, 9, -1);
                    default: load_trap(512, 512, 255, -128, 127, 3);
                endcase
                run(2'b01, c, "R2");
                run(2'b00, 5, "R6");
                run(2'b11, 5, "R6");
                run(2'b10, 0, "R7");
                run(2'b10, (c + 2) % 6, "R5");
            end
        end

        // R10: select 7 is ignored; a begin still shows the last start values.
        load_trap(100, 200, 50, 2, 4, 1);
        wr(3'd7, 16'hFFFF);
        run(2'b01, 3, "R10");
        run(2'b10, 2, "R10");

        finish_run();
    end

endmodule